// File: doc/BRIEF.md
# Robbed-bit signaling extractor

This block sits on the system-timed T1 stream after the slip buffer. It counts bit positions within each 193-bit frame and counts frames within the multiframe. During the signaling frames it captures the least significant bit of each of the 24 channels into a per-channel staging store. When a multiframe completes, and only if the external update-enable input allows it, the staged bits are copied into a presented store. The presented store drives four per-channel signaling outputs in every frame of the next multiframe. Debounce and freeze policy live elsewhere and reach this block only through the update-enable input.

Two framing types are supported. A 12-frame superframe carries two signaling bits per channel. A 24-frame extended superframe carries four. In 12-frame mode the third and fourth outputs repeat the first two outputs of the previous multiframe. The serial data passes through untouched, except in an optional fill mode that overwrites the robbed-bit positions with ones. A marker output flags the last bit of every channel, so that external logic can reinsert signaling bits.

Top module: `rbs_extract`

## Requirements
- R1: While `rst_n` is low, `ser_out`, `lsb_mark` and `sig_a`..`sig_d` are all 0.
- R2: A cycle with `frm_sync` high carries the framing bit (bit 0). Bits 1..192 follow as channels 1..24, eight bits per channel with the MSB first. One clock later, `lsb_mark` is high for the eighth bit of each channel and low for the framing bit. `mf_sync` is asserted only together with `frm_sync` and marks frame 1. Frames then count up to 12 when `esf_mode`=0, or to 24 when `esf_mode`=1, and wrap back to frame 1.
- R3: `ser_out` equals `ser_in` delayed by one clock, except at the positions overridden by R10.
- R4: With `esf_mode`=0, the LSB of each channel in frame 6 is captured as A and the LSB in frame 12 is captured as B.
- R5: With `esf_mode`=1, the LSB of each channel in frames 6, 12, 18 and 24 is captured as A, B, C and D respectively.
- R6: One clock after each bit of channel n, `sig_a`..`sig_d` show the presented A..D values of channel n. The values are the same in every frame of the multiframe. One clock after the framing bit, all four outputs are 0.
- R7: In the cycle that carries bit 192 of the last frame (12 or 24), if `upd_en` is high, the presented store takes the staged values. This includes the bit captured in that same cycle.
- R8: If `upd_en` is low in that cycle, the presented values stay unchanged throughout the following multiframe.
- R9: On an update with `esf_mode`=0, the presented C and D take the presented A and B values from before the update, while A and B take the newly staged bits.
- R10: With `fill_ones`=1, `ser_out` is 1 one clock after each signaling-frame LSB position of the current framing type: frames 6 and 12 in 12-frame mode, or frames 6, 12, 18 and 24 in 24-frame mode. All other bits pass through unchanged.
- R11: `mf_sync` restarts the frame count at frame 1 at any point. A multiframe cut short before its last frame performs no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | System-timed serial T1 data |
| frm_sync | input | 1 | High on the framing-bit cycle |
| mf_sync | input | 1 | High on the framing bit of frame 1 |
| esf_mode | input | 1 | 0 = 12-frame, 1 = 24-frame framing |
| upd_en | input | 1 | Permits the multiframe-end copy to the presented store |
| fill_ones | input | 1 | Overwrite robbed-bit positions in `ser_out` with ones |
| ser_out | output | 1 | Serial data, one clock behind `ser_in` |
| lsb_mark | output | 1 | High during each channel's last bit on `ser_out` |
| sig_a | output | 1 | Presented A bit of the current channel |
| sig_b | output | 1 | Presented B bit of the current channel |
| sig_c | output | 1 | Presented C bit of the current channel |
| sig_d | output | 1 | Presented D bit of the current channel |

## Verification
The capture of channel 24's last signaling bit and the update of the presented store fall in the same cycle. If the update used the staging store without that bit, channel 24 would present a stale value. The bench drives random data into every channel, including channel 24 of the last frame, and toggles `upd_en` on random cycles. It judges the outcome by comparing `sig_a`..`sig_d` with its own model over the whole next multiframe. In 12-frame mode, the same update cycle also shifts the old A and B into C and D, so both effects of that one cycle are checked together.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int RBS_CH_NUM      = 24;
  localparam int RBS_BITS_PER_CH = 8;
  localparam int RBS_LONG_FRAMES = 24;
  localparam int RBS_NUM_SIG     = 4;

  typedef enum logic [1:0] {
    SIG_A = 2'd0,
    SIG_B = 2'd1,
    SIG_C = 2'd2,
    SIG_D = 2'd3
  } sig_slot_e;
endpackage

// File: rtl/rbs_pos_ctr.sv
module rbs_pos_ctr #(
  parameter int FRAME_BITS  = 193,
  parameter int LONG_FRAMES = 24,
  localparam int BW = $clog2(FRAME_BITS),
  localparam int FW = $clog2(LONG_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_sync,
  input  logic          mf_sync,
  input  logic          esf_mode,
  output logic [BW-1:0] cur_bit,
  output logic [FW-1:0] cur_frame,
  output logic          mf_end
);
  logic [BW-1:0] bit_q;
  logic [FW-1:0] frm_q;
  logic [FW-1:0] last_frame;

  function automatic logic [BW-1:0] bit_after(input logic [BW-1:0] b);
    return (b == BW'(FRAME_BITS - 1)) ? '0 : b + 1'b1;
  endfunction

  assign last_frame = esf_mode ? FW'(LONG_FRAMES - 1) : FW'(LONG_FRAMES / 2 - 1);

  always_comb begin
    cur_bit = frm_sync ? '0 : bit_after(bit_q);
    if (mf_sync)
      cur_frame = '0;
    else if (cur_bit == '0)
      cur_frame = (frm_q >= last_frame) ? '0 : frm_q + 1'b1;
    else
      cur_frame = frm_q;
  end

  assign mf_end = (cur_frame == last_frame) && (cur_bit == BW'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= BW'(FRAME_BITS - 1);
      frm_q <= FW'(LONG_FRAMES - 1);
    end else begin
      bit_q <= cur_bit;
      frm_q <= cur_frame;
    end
  end
endmodule

// File: rtl/rbs_slot_dec.sv
module rbs_slot_dec #(
  parameter int CH_NUM      = 24,
  parameter int BITS_PER_CH = 8,
  parameter int LONG_FRAMES = 24,
  parameter int NUM_SIG     = 4,
  localparam int BW  = $clog2(CH_NUM * BITS_PER_CH + 1),
  localparam int FW  = $clog2(LONG_FRAMES),
  localparam int CW  = $clog2(CH_NUM),
  localparam int SW  = $clog2(NUM_SIG),
  localparam int FPS = LONG_FRAMES / NUM_SIG
) (
  input  logic [BW-1:0] cur_bit,
  input  logic [FW-1:0] cur_frame,
  input  logic          esf_mode,
  output logic [CW-1:0] chan,
  output logic          lsb_now,
  output logic          cap_en,
  output logic [SW-1:0] cap_slot
);
  function automatic logic [CW-1:0] chan_of(input logic [BW-1:0] b);
    int v;
    v = (b == '0) ? 0 : (int'(b) - 1) / BITS_PER_CH;
    return CW'(v);
  endfunction

  function automatic logic is_last_bit(input logic [BW-1:0] b);
    return (b != '0) && (((int'(b) - 1) % BITS_PER_CH) == BITS_PER_CH - 1);
  endfunction

  function automatic logic is_sig_frame(input logic [FW-1:0] f);
    return ((int'(f) + 1) % FPS) == 0;
  endfunction

  function automatic int slot_of(input logic [FW-1:0] f);
    return (int'(f) + 1) / FPS - 1;
  endfunction

  logic slot_allowed;

  always_comb begin
    chan         = chan_of(cur_bit);
    lsb_now      = is_last_bit(cur_bit);
    cap_slot     = SW'(slot_of(cur_frame));
    slot_allowed = esf_mode || (slot_of(cur_frame) < NUM_SIG / 2);
    cap_en       = lsb_now && is_sig_frame(cur_frame) && slot_allowed;
  end
endmodule

// File: rtl/rbs_sig_store.sv
module rbs_sig_store #(
  parameter int CH_NUM  = 24,
  parameter int NUM_SIG = 4,
  localparam int CW   = $clog2(CH_NUM),
  localparam int SW   = $clog2(NUM_SIG),
  localparam int HALF = NUM_SIG / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_en,
  input  logic [CW-1:0]             cap_chan,
  input  logic [SW-1:0]             cap_slot,
  input  logic                      cap_bit,
  input  logic                      commit,
  input  logic                      esf_mode,
  input  logic [CW-1:0]             rd_chan,
  output logic [NUM_SIG-1:0]        rd_sig,
  output logic [CH_NUM*NUM_SIG-1:0] pres_flat
);
  logic [NUM_SIG-1:0] pres_arr [CH_NUM];

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    logic [NUM_SIG-1:0] stage_q;
    logic [NUM_SIG-1:0] stage_nx;
    logic [NUM_SIG-1:0] pres_q;

    always_comb begin
      stage_nx = stage_q;
      if (cap_en && (cap_chan == CW'(c)))
        stage_nx[cap_slot] = cap_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        pres_q  <= '0;
      end else begin
        stage_q <= stage_nx;
        if (commit) begin
          if (esf_mode) begin
            pres_q <= stage_nx;
          end else begin
            pres_q[HALF-1:0]       <= stage_nx[HALF-1:0];
            pres_q[NUM_SIG-1:HALF] <= pres_q[HALF-1:0];
          end
        end
      end
    end

    assign pres_arr[c]                        = pres_q;
    assign pres_flat[c*NUM_SIG +: NUM_SIG]    = pres_q;
  end

  assign rd_sig = (int'(rd_chan) < CH_NUM) ? pres_arr[rd_chan] : '0;
endmodule

// File: rtl/rbs_extract.sv
module rbs_extract
  import rbs_pkg::*;
#(
  parameter int CH_NUM      = RBS_CH_NUM,
  parameter int BITS_PER_CH = RBS_BITS_PER_CH,
  parameter int LONG_FRAMES = RBS_LONG_FRAMES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  input  logic frm_sync,
  input  logic mf_sync,
  input  logic esf_mode,
  input  logic upd_en,
  input  logic fill_ones,
  output logic ser_out,
  output logic lsb_mark,
  output logic sig_a,
  output logic sig_b,
  output logic sig_c,
  output logic sig_d
);
  localparam int NUM_SIG    = RBS_NUM_SIG;
  localparam int FRAME_BITS = CH_NUM * BITS_PER_CH + 1;
  localparam int BW         = $clog2(FRAME_BITS);
  localparam int FW         = $clog2(LONG_FRAMES);
  localparam int CW         = $clog2(CH_NUM);
  localparam int SW         = $clog2(NUM_SIG);

  logic [BW-1:0]             cur_bit;
  logic [FW-1:0]             cur_frame;
  logic                      mf_end;
  logic                      commit;
  logic [CW-1:0]             chan;
  logic                      lsb_now;
  logic                      cap_en;
  logic [SW-1:0]             cap_slot;
  logic [NUM_SIG-1:0]        rd_sig;
  logic [CH_NUM*NUM_SIG-1:0] pres_flat;
  logic [NUM_SIG-1:0]        sig_q;

  rbs_pos_ctr #(
    .FRAME_BITS (FRAME_BITS),
    .LONG_FRAMES(LONG_FRAMES)
  ) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_sync (frm_sync),
    .mf_sync  (mf_sync),
    .esf_mode (esf_mode),
    .cur_bit  (cur_bit),
    .cur_frame(cur_frame),
    .mf_end   (mf_end)
  );

  rbs_slot_dec #(
    .CH_NUM     (CH_NUM),
    .BITS_PER_CH(BITS_PER_CH),
    .LONG_FRAMES(LONG_FRAMES),
    .NUM_SIG    (NUM_SIG)
  ) u_dec (
    .cur_bit  (cur_bit),
    .cur_frame(cur_frame),
    .esf_mode (esf_mode),
    .chan     (chan),
    .lsb_now  (lsb_now),
    .cap_en   (cap_en),
    .cap_slot (cap_slot)
  );

  assign commit = mf_end && upd_en;

  rbs_sig_store #(
    .CH_NUM (CH_NUM),
    .NUM_SIG(NUM_SIG)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_chan (chan),
    .cap_slot (cap_slot),
    .cap_bit  (ser_in),
    .commit   (commit),
    .esf_mode (esf_mode),
    .rd_chan  (chan),
    .rd_sig   (rd_sig),
    .pres_flat(pres_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_out  <= 1'b0;
      lsb_mark <= 1'b0;
      sig_q    <= '0;
    end else begin
      ser_out  <= (fill_ones && cap_en) ? 1'b1 : ser_in;
      lsb_mark <= lsb_now;
      sig_q    <= (cur_bit == '0) ? '0 : rd_sig;
    end
  end

  assign sig_a = sig_q[SIG_A];
  assign sig_b = sig_q[SIG_B];
  assign sig_c = sig_q[SIG_C];
  assign sig_d = sig_q[SIG_D];
endmodule

// File: rtl/rbs_extract_chk.sv
module rbs_extract_chk
  import rbs_pkg::*;
#(
  parameter int CH_NUM      = RBS_CH_NUM,
  parameter int BITS_PER_CH = RBS_BITS_PER_CH,
  parameter int LONG_FRAMES = RBS_LONG_FRAMES,
  localparam int NUM_SIG = RBS_NUM_SIG,
  localparam int BW      = $clog2(CH_NUM * BITS_PER_CH + 1),
  localparam int FW      = $clog2(LONG_FRAMES),
  localparam int HALF    = NUM_SIG / 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ser_in,
  input logic                      ser_out,
  input logic                      fill_ones,
  input logic                      lsb_mark,
  input logic                      sig_a,
  input logic                      sig_b,
  input logic                      sig_c,
  input logic                      sig_d,
  input logic                      esf_mode,
  input logic [BW-1:0]             cur_bit,
  input logic [FW-1:0]             cur_frame,
  input logic                      cap_en,
  input logic                      commit,
  input logic [CH_NUM*NUM_SIG-1:0] pres_flat
);
  assert_frame_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_frame) < LONG_FRAMES);

  assert_fbit_not_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bit == '0) |=> !lsb_mark);

  assert_fbit_sig_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bit == '0) |=> !(sig_a || sig_b || sig_c || sig_d));

  assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_ones |=> (ser_out == $past(ser_in)));

  assert_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ones && cap_en) |=> ser_out);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(pres_flat));

  for (genvar c = 0; c < CH_NUM; c++) begin : g_carry
    for (genvar s = 0; s < HALF; s++) begin : g_sig
      assert_sf_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !esf_mode) |=>
          (pres_flat[c*NUM_SIG + HALF + s] == $past(pres_flat[c*NUM_SIG + s])));
    end
  end
endmodule

bind rbs_extract rbs_extract_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_in   (ser_in),
  .ser_out  (ser_out),
  .fill_ones(fill_ones),
  .lsb_mark (lsb_mark),
  .sig_a    (sig_a),
  .sig_b    (sig_b),
  .sig_c    (sig_c),
  .sig_d    (sig_d),
  .esf_mode (esf_mode),
  .cur_bit  (cur_bit),
  .cur_frame(cur_frame),
  .cap_en   (cap_en),
  .commit   (commit),
  .pres_flat(pres_flat)
);

// File: tb/tb_rbs_extract.sv
module tb_rbs_extract;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 24;
  localparam int FBITS      = 193;

  logic clk = 1'b0;
  logic rst_n, ser_in, frm_sync, mf_sync, esf_mode, upd_en, fill_ones;
  logic ser_out, lsb_mark, sig_a, sig_b, sig_c, sig_d;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model state: bit0=A bit1=B bit2=C bit3=D
  logic [3:0] stage [NCH];
  logic [3:0] pres  [NCH];
  logic       exp_ser, exp_lsb;
  logic [3:0] exp_sig;
  bit         exp_valid = 1'b0;
  string      ser_tag, sig_tag;
  bit         m_esf, m_upd, m_fill;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rbs_extract dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .frm_sync(frm_sync),
    .mf_sync(mf_sync), .esf_mode(esf_mode), .upd_en(upd_en),
    .fill_ones(fill_ones), .ser_out(ser_out), .lsb_mark(lsb_mark),
    .sig_a(sig_a), .sig_b(sig_b), .sig_c(sig_c), .sig_d(sig_d)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_out();
    if (exp_valid) begin
      check({3'b0, ser_out}, {3'b0, exp_ser}, ser_tag);
      check({3'b0, lsb_mark}, {3'b0, exp_lsb}, "R2 lsb_mark");
      check({sig_d, sig_c, sig_b, sig_a}, exp_sig, sig_tag);
    end
  endtask

  task automatic step(input int f, input int b, input bit din, input bit ms, input int full);
    int  ch, slot;
    bit  lsb, cap;
    @(negedge clk);
    compare_out();
    ser_in    = din;
    frm_sync  = (b == 0);
    mf_sync   = ms;
    esf_mode  = m_esf;
    upd_en    = m_upd;
    fill_ones = m_fill;
    lsb  = (b != 0) && (((b - 1) % 8) == 7);
    ch   = (b == 0) ? 0 : (b - 1) / 8;
    slot = (f + 1) / 6 - 1;
    cap  = lsb && (((f + 1) % 6) == 0) && (m_esf || slot < 2);
    exp_ser = (m_fill && cap) ? 1'b1 : din;
    exp_lsb = lsb;
    exp_sig = (b == 0) ? 4'h0 : pres[ch];
    ser_tag = m_fill ? "R10 fill ser_out" : "R3 ser_out pass";
    exp_valid = 1'b1;
    if (cap) stage[ch][slot] = din;
    if (b == FBITS - 1 && f == full - 1 && m_upd) begin
      for (int c = 0; c < NCH; c++) begin
        if (m_esf) pres[c] = stage[c];
        else       pres[c] = {pres[c][1], pres[c][0], stage[c][1], stage[c][0]};
      end
    end
  endtask

  task automatic run_mf(input int nfr, input bit rand_upd);
    int full;
    full = m_esf ? 24 : 12;
    for (int f = 0; f < nfr; f++) begin
      for (int b = 0; b < FBITS; b++) begin
        if (rand_upd) m_upd = 1'($urandom);
        step(f, b, 1'($urandom), (f == 0) && (b == 0), full);
      end
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      stage[c] = 4'h0;
      pres[c]  = 4'h0;
    end
    rst_n = 1'b0; ser_in = 1'b1; frm_sync = 1'b0; mf_sync = 1'b0;
    esf_mode = 1'b0; upd_en = 1'b1; fill_ones = 1'b1;
    m_esf = 1'b0; m_upd = 1'b1; m_fill = 1'b0;
    repeat (3) @(negedge clk);
    check({ser_out, lsb_mark, 2'b0}, 4'h0, "R1 reset ser_out/lsb_mark");
    check({sig_d, sig_c, sig_b, sig_a}, 4'h0, "R1 reset sig outputs");
    rst_n = 1'b1;

    sig_tag = "R4 R6 R7 R9 12-frame sig";
    run_mf(12, 1'b0); run_mf(12, 1'b0); run_mf(12, 1'b0);
    sig_tag = "R8 12-frame update blocked";
    m_upd = 1'b0; run_mf(12, 1'b0); run_mf(12, 1'b0);
    sig_tag = "R9 12-frame carry of A/B";
    m_upd = 1'b1; run_mf(12, 1'b0); run_mf(12, 1'b0);

    sig_tag = "R5 R6 R7 24-frame sig";
    m_esf = 1'b1; run_mf(24, 1'b0); run_mf(24, 1'b0);
    sig_tag = "R8 24-frame update blocked";
    m_upd = 1'b0; run_mf(24, 1'b0); run_mf(24, 1'b0);
    sig_tag = "R7 update enable sampled at last bit";
    run_mf(24, 1'b1); m_upd = 1'b1; run_mf(24, 1'b0);

    sig_tag = "R11 shortened multiframe";
    run_mf(10, 1'b0); run_mf(24, 1'b0);
    m_esf = 1'b0; run_mf(5, 1'b0); run_mf(12, 1'b0);

    sig_tag = "R10 R6 fill mode sig";
    m_fill = 1'b1; run_mf(12, 1'b0);
    m_esf = 1'b1; run_mf(24, 1'b0);
    m_fill = 1'b0; run_mf(2, 1'b0);

    @(negedge clk);
    compare_out();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule